// File: doc/BRIEF.md
# Watchdog Timer with Feed Sequence and Reset-Cause Capture

This block is a watchdog for a small microcontroller. Software reaches it over an 8-bit register bus. A prescaler divides the clock by a power of two, and each prescaled tick decrements an 8-bit down-counter. If the counter is found at zero on a tick while the watchdog runs, the block raises a one-cycle system reset request. It also sets a timeout flag and records the watchdog as the reset cause. Software restarts the count with a two-write unlock sequence: key A5h to the first feed register, then key 5Ah to the second, with no other bus access in between.

A four-state feed tracker enforces both the feed order and the stop rule. Its states are `FD_IDLE`, `FD_HALF`, `FD_STOP_WAIT` and `FD_STOP_HALF`. Any bus access returns the tracker to `FD_IDLE` unless the access is one of the following:
- Writing key A5h to the first feed register moves `FD_STOP_WAIT` to `FD_STOP_HALF`, and moves every other state to `FD_HALF`.
- Writing 0 to the run bit while the watchdog is running moves any state to `FD_STOP_WAIT`.
- Writing key 5Ah to the second feed register from `FD_HALF` or `FD_STOP_HALF` performs a feed. From `FD_STOP_HALF` it also stops the watchdog.

Cycles with no bus access hold the current state.

The reset controller drives a synchronous reset together with a one-hot cause vector: bit 0 power-on, bit 1 external pin, bit 2 watchdog. The block loads its control register according to that cause. The cause register also holds a software enable for the reset-output pin.

Top module: `wdog_ctrl`

## Requirements
- R1: During reset the control register loads E6h if the cause vector has its watchdog bit (bit 2) set, and E4h otherwise. The reload register loads 00h. The cause register loads the cause vector in bits 2:0 and clears its output-enable bit 7.
- R2: Addresses: control 41Fh, reload 45Fh, feed one 45Dh, feed two 45Eh, cause 463h. Control reads return prescale select in bits 7:5, run in bit 2 and timeout flag in bit 1, with bits 4, 3 and 0 always 0. Feed registers and unmapped addresses read 0, and read data bits 15:8 are always 0.
- R3: A write uses only bits 7:0 of the write data, so a 16-bit write changes only the low byte.
- R4: With the watchdog running, the counter decrements once every 2^(5+PRE) clock cycles. With run at 0, neither the prescaler nor the counter moves.
- R5: A tick that finds the counter at zero causes the following effects. `wdt_rst_req` is high for exactly one cycle in the next cycle. The timeout flag is set, the cause bits become 100b, and the counter reloads.
- R6: A valid feed (A5h to 45Dh, then 5Ah to 45Eh, with no access between) reloads the counter from the reload register and clears the prescaler at the second write.
- R7: A feed with a wrong key, keys in the wrong order, or any bus access between the two writes does not restart the count.
- R8: Writing run=0 stops the watchdog only if the next two bus accesses are a valid feed. Otherwise run stays 1.
- R9: A write flagged as read-modify-write that carries flag=0 leaves the flag set if hardware set it since the last control read or write. A plain write of 0 clears it.
- R10: Bit 7 of the cause register is writable and drives `rst_out_en`. Cause bits 2:0 ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rst_cause | input | 3 | One-hot cause of the current reset |
| bus_addr | input | 11 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rmw | input | 1 | Marks a write as the write-back of a read-modify-write |
| bus_wdata | input | 16 | Write data, bits 7:0 used |
| bus_rdata | output | 16 | Read data, bits 15:8 zero |
| wdt_rst_req | output | 1 | One-cycle system reset request |
| rst_out_en | output | 1 | Enable for the reset-output pin |

## Verification
The bench measures the distance between a feed and the reset request. A prescaler off by one cycle, or a feed that fails to clear the prescaler, shifts the 128- or 256-cycle result. It feeds twice, 100 cycles apart, to catch a design that ignores a second feed. It also breaks the feed with a wrong key, a swapped order and an intervening read; a tracker that forgets its state on a bus access would restart the count early. The bench times a read-modify-write write-back so that it lands after a timeout. A design without the guard loses the flag, and a guard that never clears keeps the flag after a later write-back. Finally, it tries a stop with a read between the run write and the feed, where a lax design stops the watchdog.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int ADDR_W  = 11;
    localparam int DATA_W  = 16;
    localparam int CAUSE_W = 3;
    localparam int CAUSE_WDT = 2;

    localparam logic [ADDR_W-1:0] A_CTRL   = 11'h41F;
    localparam logic [ADDR_W-1:0] A_RELOAD = 11'h45F;
    localparam logic [ADDR_W-1:0] A_FEED1  = 11'h45D;
    localparam logic [ADDR_W-1:0] A_FEED2  = 11'h45E;
    localparam logic [ADDR_W-1:0] A_RSRC   = 11'h463;

    localparam logic [7:0] KEY1 = 8'hA5;
    localparam logic [7:0] KEY2 = 8'h5A;

    typedef enum logic [1:0] {
        FD_IDLE,
        FD_HALF,
        FD_STOP_WAIT,
        FD_STOP_HALF
    } feed_st_e;
endpackage

// File: rtl/wdog_feed_fsm.sv
module wdog_feed_fsm
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic acc,
    input  logic key1_wr,
    input  logic key2_wr,
    input  logic stop_wr,
    output logic feed_ok,
    output logic stop_ok
);
    feed_st_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= FD_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (acc) begin
            state_d = FD_IDLE;
            unique case (state_q)
                FD_STOP_WAIT: begin
                    if (key1_wr)      state_d = FD_STOP_HALF;
                    else if (stop_wr) state_d = FD_STOP_WAIT;
                end
                FD_IDLE, FD_HALF, FD_STOP_HALF: begin
                    if (key1_wr)      state_d = FD_HALF;
                    else if (stop_wr) state_d = FD_STOP_WAIT;
                end
            endcase
        end
    end

    always_comb begin
        feed_ok = 1'b0;
        stop_ok = 1'b0;
        unique case (state_q)
            FD_HALF:      feed_ok = key2_wr;
            FD_STOP_HALF: begin
                feed_ok = key2_wr;
                stop_ok = key2_wr;
            end
            FD_IDLE, FD_STOP_WAIT: ;
        endcase
    end
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int PRE_W   = 3,
    parameter int BASE_SH = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             clr,
    input  logic [PRE_W-1:0] sel,
    output logic             tick
);
    localparam int MAX_SEL = (1 << PRE_W) - 1;
    localparam int PS_W    = BASE_SH + MAX_SEL;

    logic [PS_W-1:0] cnt_q;
    logic [PS_W-1:0] last;

    always_comb begin
        last = {PS_W{1'b1}} >> (PRE_W'(MAX_SEL) - sel);
        tick = run && (cnt_q >= last);
    end

    always_ff @(posedge clk) begin
        if (rst || clr)  cnt_q <= '0;
        else if (tick)   cnt_q <= '0;
        else if (run)    cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/wdog_down_counter.sv
module wdog_down_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] reload,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    assign expire = tick && !load && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (load) cnt_q <= reload;
        else if (tick) cnt_q <= (cnt_q == '0) ? reload : cnt_q - 1'b1;
    end
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
    import wdog_pkg::*;
#(
    parameter int PRE_W   = 3,
    parameter int BASE_SH = 5,
    parameter int CNT_W   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CAUSE_W-1:0] rst_cause,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic               bus_rmw,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               wdt_rst_req,
    output logic               rst_out_en
);
    localparam int PAD_W = 8 - 1 - CAUSE_W;
    localparam logic [CAUSE_W-1:0] WDT_HOT = CAUSE_W'(1) << CAUSE_WDT;

    logic [7:0]         wd;
    logic               acc, ctrl_wr, ctrl_rd, key1_wr, key2_wr, stop_wr;
    logic               feed_ok, stop_ok, tick, expire;
    logic [PRE_W-1:0]   pre_q;
    logic               run_q, flag_q, pend_q, en_q, req_q;
    logic [CNT_W-1:0]   reload_q;
    logic [CAUSE_W-1:0] cause_q;

    always_comb begin
        wd      = bus_wdata[7:0];
        acc     = bus_rd || bus_wr;
        ctrl_wr = bus_wr && (bus_addr == A_CTRL);
        ctrl_rd = bus_rd && (bus_addr == A_CTRL);
        key1_wr = bus_wr && (bus_addr == A_FEED1) && (wd == KEY1);
        key2_wr = bus_wr && (bus_addr == A_FEED2) && (wd == KEY2);
        stop_wr = ctrl_wr && !wd[2] && run_q;
    end

    wdog_feed_fsm u_feed (
        .clk(clk), .rst(rst), .acc(acc),
        .key1_wr(key1_wr), .key2_wr(key2_wr), .stop_wr(stop_wr),
        .feed_ok(feed_ok), .stop_ok(stop_ok)
    );

    wdog_prescaler #(.PRE_W(PRE_W), .BASE_SH(BASE_SH)) u_presc (
        .clk(clk), .rst(rst), .run(run_q), .clr(feed_ok),
        .sel(pre_q), .tick(tick)
    );

    wdog_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .load(feed_ok),
        .reload(reload_q), .expire(expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q    <= '1;
            run_q    <= 1'b1;
            flag_q   <= rst_cause[CAUSE_WDT];
            pend_q   <= 1'b0;
            reload_q <= '0;
            en_q     <= 1'b0;
            cause_q  <= rst_cause;
            req_q    <= 1'b0;
        end else begin
            req_q <= expire;
            if (ctrl_wr) begin
                pre_q <= wd[7:5];
                if (wd[2]) run_q <= 1'b1;
            end else if (stop_ok) begin
                run_q <= 1'b0;
            end
            if (expire)                          flag_q <= 1'b1;
            else if (ctrl_wr && !(bus_rmw && pend_q)) flag_q <= wd[1];
            if (expire)                          pend_q <= 1'b1;
            else if (ctrl_wr || ctrl_rd)         pend_q <= 1'b0;
            if (bus_wr && bus_addr == A_RELOAD)  reload_q <= wd[CNT_W-1:0];
            if (bus_wr && bus_addr == A_RSRC)    en_q <= wd[7];
            if (expire)                          cause_q <= WDT_HOT;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                A_CTRL:   bus_rdata[7:0] = {pre_q, 2'b00, run_q, flag_q, 1'b0};
                A_RELOAD: bus_rdata[7:0] = reload_q;
                A_RSRC:   bus_rdata[7:0] = {en_q, {PAD_W{1'b0}}, cause_q};
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign wdt_rst_req = req_q;
    assign rst_out_en  = en_q;
endmodule

// File: rtl/wdog_ctrl_chk.sv
module wdog_ctrl_chk
    import wdog_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_rd,
    input logic               bus_wr,
    input logic               bus_rmw,
    input logic [7:0]         wlo,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic               wdt_rst_req,
    input logic               flag,
    input logic               run,
    input logic               pend,
    input logic [CAUSE_W-1:0] cause,
    input logic [7:0]         reload
);
    p_req_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        wdt_rst_req |=> !wdt_rst_req);
    p_req_flag_r5: assert property (@(posedge clk) disable iff (rst)
        wdt_rst_req |-> flag);
    p_req_cause_r5: assert property (@(posedge clk) disable iff (rst)
        wdt_rst_req |-> cause == (CAUSE_W'(1) << CAUSE_WDT));
    p_cause_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        $countones(cause) == 1);
    p_rd_hi_zero_r2: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[15:8] == 8'h00);
    p_ctrl_unimpl_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == A_CTRL) |-> (bus_rdata[4:3] == 2'b00 && !bus_rdata[0]));
    p_reload_low_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_RELOAD) |=> reload == $past(wlo));
    p_guard_keep_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_rmw && pend && bus_addr == A_CTRL) |=> flag);
    p_stop_by_feed_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(run) |-> $past(bus_wr && bus_addr == A_FEED2 && wlo == KEY2));
endmodule

bind wdog_ctrl wdog_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_rmw(bus_rmw), .wlo(bus_wdata[7:0]),
    .bus_rdata(bus_rdata), .wdt_rst_req(wdt_rst_req), .flag(flag_q),
    .run(run_q), .pend(pend_q), .cause(cause_q), .reload(reload_q)
);

// File: tb/wdog_ctrl_test.sv
module wdog_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  rst_cause = 3'b001;
    logic [10:0] bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0, bus_rmw = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        wdt_rst_req, rst_out_en;

    int checks = 0, errors = 0, cyc = 0;
    string cur_tag = "R1";

    // behavioural model state
    int m_pre = 7, m_run = 1, m_presc = 0, m_cnt = 0, m_st = 0;
    int m_reload = 0, m_en = 0, m_req = 0;

    localparam logic [10:0] CTRL = 11'h41F, RELD = 11'h45F, FD1 = 11'h45D,
                            FD2 = 11'h45E, RSRC = 11'h463;

    wdog_ctrl uut (
        .clk(clk), .rst(rst), .rst_cause(rst_cause), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rmw(bus_rmw),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdt_rst_req(wdt_rst_req), .rst_out_en(rst_out_en)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        int lim, w, ns;
        bit acc, k1, k2, cw, feed, stopnow, tick, expd;
        cyc++;
        if (rst) begin
            m_pre = 7; m_run = 1; m_presc = 0; m_cnt = 0; m_st = 0;
            m_reload = 0; m_en = 0; m_req = 0;
        end else begin
            lim = 1 << (5 + m_pre);
            w   = int'(bus_wdata[7:0]);
            acc = bus_rd || bus_wr;
            k1  = bus_wr && bus_addr == FD1 && w == 'hA5;
            k2  = bus_wr && bus_addr == FD2 && w == 'h5A;
            cw  = bus_wr && bus_addr == CTRL;
            feed    = k2 && (m_st == 1 || m_st == 3);
            stopnow = k2 && m_st == 3;
            tick    = m_run != 0 && m_presc >= lim - 1;
            expd    = tick && m_cnt == 0 && !feed;
            m_req   = expd ? 1 : 0;
            if (feed) begin m_presc = 0; m_cnt = m_reload; end
            else if (tick) begin
                m_presc = 0;
                m_cnt = (m_cnt == 0) ? m_reload : m_cnt - 1;
            end else if (m_run != 0) m_presc++;
            if (acc) begin
                ns = 0;
                if (k1) ns = (m_st == 2) ? 3 : 1;
                else if (cw && (w & 4) == 0 && m_run != 0) ns = 2;
                m_st = ns;
            end
            if (cw) begin
                m_pre = (w >> 5) & 7;
                if ((w & 4) != 0) m_run = 1;
            end else if (stopnow) m_run = 0;
            if (bus_wr && bus_addr == RELD) m_reload = w;
            if (bus_wr && bus_addr == RSRC) m_en = (w >> 7) & 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            check(wdt_rst_req == m_req[0], {cur_tag, " req vs model"}, int'(wdt_rst_req), m_req);
            check(rst_out_en == m_en[0], "R10 out-enable vs model", int'(rst_out_en), m_en);
        end
    end

    task automatic wr(input logic [10:0] a, input logic [15:0] d, input logic rmw);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rmw = rmw;
        @(negedge clk);
        bus_wr = 1'b0; bus_rmw = 1'b0;
    endtask

    task automatic rd(input logic [10:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        check(bus_rdata == exp, tag, int'(bus_rdata), int'(exp));
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic do_reset(input logic [2:0] c);
        @(negedge clk);
        rst = 1'b1; rst_cause = c;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic feed();
        wr(FD1, 16'h00A5, 1'b0);
        wr(FD2, 16'h005A, 1'b0);
    endtask

    task automatic req_after(input int t0, input int exp, input string tag);
        int d = -1;
        for (int i = 0; i < exp + 64; i++) begin
            if (wdt_rst_req) begin d = cyc - t0; break; end
            @(negedge clk);
        end
        check(d == exp, tag, d, exp);
        @(negedge clk);
        check(!wdt_rst_req, {tag, " single pulse R5"}, int'(wdt_rst_req), 0);
    endtask

    initial begin
        int t0, pulses;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cur_tag = "R1";
        rd(CTRL, 16'h00E4, "R1 ctrl after power-on");
        rd(RELD, 16'h0000, "R1 reload after reset");
        rd(RSRC, 16'h0001, "R1 cause after power-on");
        wr(RELD, 16'hAB03, 1'b0);
        rd(RELD, 16'h0003, "R3 wide write low byte only");
        wr(CTRL, 16'h00FF, 1'b0);
        rd(CTRL, 16'h00E6, "R2 unimplemented bits read 0");
        rd(FD1, 16'h0000, "R2 feed register reads 0");
        do_reset(3'b100);
        rd(CTRL, 16'h00E6, "R1 ctrl after watchdog reset");
        rd(RSRC, 16'h0004, "R1 cause watchdog");
        do_reset(3'b010);
        rd(CTRL, 16'h00E4, "R1 ctrl after pin reset");
        rd(RSRC, 16'h0002, "R1 cause pin");

        cur_tag = "R5";
        wr(RELD, 16'h0003, 1'b0);
        feed();
        wr(CTRL, 16'h0004, 1'b0);
        feed(); t0 = cyc;
        req_after(t0, 128, "R4 R6 timeout 4 ticks of 32");
        rd(CTRL, 16'h0006, "R5 flag set by timeout");
        rd(RSRC, 16'h0004, "R5 cause becomes watchdog");

        cur_tag = "R6";
        feed();
        repeat (100) @(negedge clk);
        feed(); t0 = cyc;
        req_after(t0, 128, "R6 second feed restarts count");

        cur_tag = "R7";
        feed(); t0 = cyc;
        wr(FD1, 16'h005A, 1'b0); wr(FD2, 16'h00A5, 1'b0);
        wr(FD1, 16'h00A5, 1'b0); rd(CTRL, 16'h0006, "R7 read between keys");
        wr(FD2, 16'h005A, 1'b0);
        wr(FD1, 16'h00A6, 1'b0); wr(FD2, 16'h005A, 1'b0);
        req_after(t0, 128, "R7 broken feeds ignored");

        cur_tag = "R9";
        wr(CTRL, 16'h0004, 1'b0);
        rd(CTRL, 16'h0004, "R9 plain write clears flag");
        feed(); t0 = cyc;
        req_after(t0, 128, "R9 timeout before write-back");
        wr(CTRL, 16'h0004, 1'b1);
        rd(CTRL, 16'h0006, "R9 guarded write-back keeps flag");
        wr(CTRL, 16'h0004, 1'b1);
        rd(CTRL, 16'h0004, "R9 write-back after read clears");

        cur_tag = "R8";
        feed();
        wr(CTRL, 16'h0000, 1'b0);
        rd(CTRL, 16'h0004, "R8 stop without feed ignored");
        wr(CTRL, 16'h0000, 1'b0);
        feed();
        rd(CTRL, 16'h0000, "R8 stop with immediate feed");
        pulses = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (wdt_rst_req) pulses++;
        end
        check(pulses == 0, "R4 R8 stopped watchdog silent", pulses, 0);

        cur_tag = "R10";
        wr(RSRC, 16'h00FF, 1'b0);
        rd(RSRC, 16'h0084, "R10 enable writable, cause read-only");
        check(rst_out_en == 1'b1, "R10 out-enable pin", int'(rst_out_en), 1);

        cur_tag = "R4";
        wr(CTRL, 16'h0024, 1'b0); t0 = cyc;
        req_after(t0, 256, "R4 prescale 64 restart");

        do_reset(3'b010);
        rd(RSRC, 16'h0002, "R1 R10 cause and enable after reset");
        check(rst_out_en == 1'b0, "R10 out-enable cleared by reset", int'(rst_out_en), 0);
        rd(16'h123, 16'h0000, "R2 unmapped read 0");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule